// File: doc/BRIEF.md
# Cache ECC Error Logging Unit

This unit sits beside a set-associative cache whose data array is protected by ECC and whose tag array is protected by parity. The cache pipeline raises a one-cycle error pulse with a description of the fault. The description gives the error class, the requester that caused the access, the transaction kind, the line address, the set index and the way. The unit keeps two saturating tallies, one for correctable and one for uncorrectable faults. It freezes the full description of one fault until software acknowledges it.

For test, software can arm a single injected fault. It writes a target address and an enable code. The next cache access that falls in the target's 16-byte block raises a fault-request strobe toward the cache. A 32-bit corruption mask goes with the strobe. The arming then drops by itself. All state is reached through a plain word-indexed register port. Reads are combinational and writes take effect at the clock edge.

Top module: `cache_err_log`

## Requirements
- R1: Registers sit at word indices 0 (tallies), 1 (attributes), 2 (line address), 3 (location), 4 (injection control) and 5 (injection mask). Indices 6 and 7 read zero. After reset, every register reads zero.
- R2: Word 0 shows the correctable tally in bits 15:0 and the uncorrectable tally in bits 30:16. Bit 31 reads zero. An error pulse of class 0 adds one to the correctable tally. Classes 1 (uncorrectable ECC) and 2 (tag parity) add one to the uncorrectable tally. Class 3 changes no register at all.
- R3: Each tally stops at its all-ones value (16'hFFFF and 15'h7FFF) and never wraps to zero.
- R4: A write to word 0 with bit 31 set zeroes both tallies. If an error arrives in that same cycle, its tally ends at 1.
- R5: When no record is held, an error of class 0, 1 or 2 is captured and the held flag is set. Word 1 then shows the held flag in bit 0, the class in bits 9:8, the transaction kind in bits 15:12 and the requester in bits 18:16.
- R6: While a record is held, later errors update only the tallies. Words 1, 2 and 3 keep the first error's details.
- R7: Writing word 1 with bit 0 set drops the held flag. Writing it with bit 0 clear has no effect. An error that arrives in the same cycle as a drop is captured as the new record.
- R8: Word 2 returns the captured line address with bits 4:0 forced to zero. Word 3 returns the set index in bits 19:8 and the way in bits 4:1, with all other bits zero.
- R9: Word 4 holds a target address in bits 31:4 and an enable code in bits 1:0. Code 1 arms an ECC fault and code 2 arms a tag-parity fault. Codes 0 and 3 arm nothing. Word 5 is a 32-bit mask that drives `inj_mask` continuously.
- R10: While a fault is armed, an access whose address bits 31:4 equal the target raises `inj_ecc` (code 1) or `inj_parity` (code 2) in the same cycle. An access outside the block raises neither strobe. After a fault fires, the enable code reads zero and no further fault fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | One-cycle error event from the cache pipeline |
| err_kind | input | 2 | Error class: 0 correctable, 1 uncorrectable, 2 tag parity |
| err_src | input | 3 | Requester code: 0-3 core, 7 IO |
| err_txn | input | 4 | Transaction kind code |
| err_addr | input | 32 | Failing line address |
| err_set | input | 12 | Set index of the failing line |
| err_way | input | 4 | Way of the failing line |
| acc_valid | input | 1 | Cache access presented for injection matching |
| acc_addr | input | 32 | Address of that access |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| inj_ecc | output | 1 | Inject an ECC fault on the current access |
| inj_parity | output | 1 | Inject a tag-parity fault on the current access |
| inj_mask | output | 32 | Bits to corrupt on an injected fault |

## Verification
On every cycle, the assertions watch several properties. They check that a held record is never overwritten, that tallies never wrap and that a tally clear really zeroes them. They also check that the two fault strobes never fire together and that a fired fault leaves the unit disarmed. The field layout of each word can only be shown by the bench's scenarios, because each scenario has a known event in and a known word out. The same goes for first-error capture, the precedence when a clear and an error meet in one cycle, and saturation after tens of thousands of events.

// File: rtl/cache_err_log.sv
module cache_err_log #(
  parameter int CE_W  = 16,
  parameter int UE_W  = 15,
  parameter int SET_W = 12,
  parameter int WAY_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        err_valid,
  input  logic [1:0]  err_kind,
  input  logic [2:0]  err_src,
  input  logic [3:0]  err_txn,
  input  logic [31:0] err_addr,
  input  logic [11:0] err_set,
  input  logic [3:0]  err_way,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        reg_wen,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        inj_ecc,
  output logic        inj_parity,
  output logic [31:0] inj_mask
);
  localparam logic [CE_W-1:0] CE_MAX = '1;
  localparam logic [UE_W-1:0] UE_MAX = '1;
  localparam logic [2:0] W_CNT = 3'd0, W_ATTR = 3'd1, W_LINE = 3'd2,
                         W_LOC = 3'd3, W_ICTL = 3'd4, W_IMSK = 3'd5;

  logic [CE_W-1:0]  ce_cnt;
  logic [UE_W-1:0]  ue_cnt;
  logic             held;
  logic [1:0]       cap_kind;
  logic [2:0]       cap_src;
  logic [3:0]       cap_txn;
  logic [26:0]      cap_line;
  logic [SET_W-1:0] cap_set;
  logic [WAY_W-1:0] cap_way;
  logic [27:0]      tgt;
  logic [1:0]       arm;
  logic [31:0]      mask_q;

  logic ce_hit, ue_hit, cnt_clr, cap_clr, cap_take, ctl_wr, blk_match, inj_fire;
  logic unused_low;

  assign ce_hit   = err_valid && err_kind == 2'd0;
  assign ue_hit   = err_valid && (err_kind == 2'd1 || err_kind == 2'd2);
  assign cnt_clr  = reg_wen && reg_addr == W_CNT && reg_wdata[31];
  assign cap_clr  = reg_wen && reg_addr == W_ATTR && reg_wdata[0];
  assign cap_take = (ce_hit || ue_hit) && (!held || cap_clr);
  assign ctl_wr   = reg_wen && reg_addr == W_ICTL;

  assign blk_match  = acc_valid && acc_addr[31:4] == tgt;
  assign inj_ecc    = blk_match && arm == 2'd1;
  assign inj_parity = blk_match && arm == 2'd2;
  assign inj_fire   = inj_ecc || inj_parity;
  assign inj_mask   = mask_q;
  assign unused_low = ^{err_addr[4:0], acc_addr[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_cnt <= '0;
      ue_cnt <= '0;
    end else if (cnt_clr) begin
      ce_cnt <= ce_hit ? CE_W'(1) : '0;
      ue_cnt <= ue_hit ? UE_W'(1) : '0;
    end else begin
      if (ce_hit && ce_cnt != CE_MAX) ce_cnt <= ce_cnt + 1'b1;
      if (ue_hit && ue_cnt != UE_MAX) ue_cnt <= ue_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      cap_kind <= '0;
      cap_src  <= '0;
      cap_txn  <= '0;
      cap_line <= '0;
      cap_set  <= '0;
      cap_way  <= '0;
    end else if (cap_take) begin
      held     <= 1'b1;
      cap_kind <= err_kind;
      cap_src  <= err_src;
      cap_txn  <= err_txn;
      cap_line <= err_addr[31:5];
      cap_set  <= err_set;
      cap_way  <= err_way;
    end else if (cap_clr) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt    <= '0;
      arm    <= '0;
      mask_q <= '0;
    end else begin
      if (ctl_wr) begin
        tgt <= reg_wdata[31:4];
        arm <= reg_wdata[1:0];
      end else if (inj_fire) begin
        arm <= 2'd0;
      end
      if (reg_wen && reg_addr == W_IMSK) mask_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      W_CNT:  reg_rdata = {1'b0, ue_cnt, ce_cnt};
      W_ATTR: reg_rdata = {13'd0, cap_src, cap_txn, 2'd0, cap_kind, 7'd0, held};
      W_LINE: reg_rdata = {cap_line, 5'd0};
      W_LOC:  reg_rdata = {12'd0, cap_set, 3'd0, cap_way, 1'b0};
      W_ICTL: reg_rdata = {tgt, 2'd0, arm};
      W_IMSK: reg_rdata = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r3_no_wrap_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_cnt == CE_MAX && !cnt_clr) |=> ce_cnt == CE_MAX);
  a_r3_no_wrap_ue: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_cnt == UE_MAX && !cnt_clr) |=> ue_cnt == UE_MAX);
  a_r2_ce_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_hit && !cnt_clr && ce_cnt != CE_MAX) |=> ce_cnt == $past(ce_cnt) + 1'b1);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && !err_valid) |=> (ce_cnt == '0 && ue_cnt == '0));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cap_clr) |=> ($stable(cap_line) && $stable(cap_kind) && $stable(cap_set)
                           && $stable(cap_way) && $stable(cap_src) && held));
  a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(inj_ecc && inj_parity));
  a_r10_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_fire && !ctl_wr) |=> arm == 2'd0);
endmodule

// File: tb/cache_err_log_tb.sv
module cache_err_log_tb;
  localparam int PER = 10;
  localparam int NV = 6;
  // fields: kind[56:55] src[54:52] txn[51:48] addr[47:16] set[15:4] way[3:0]
  localparam logic [56:0] VEC [NV] = '{
    {2'd0, 3'd0, 4'd0, 32'h1000_0040, 12'h001, 4'd0},
    {2'd1, 3'd3, 4'd4, 32'hFFFF_FFFF, 12'hFFF, 4'hF},
    {2'd2, 3'd7, 4'd2, 32'h8765_432F, 12'hA5C, 4'd9},
    {2'd3, 3'd1, 4'd1, 32'h0BAD_0BAD, 12'h123, 4'd3},
    {2'd0, 3'd2, 4'd3, 32'h0000_003F, 12'h800, 4'd1},
    {2'd1, 3'd1, 4'd1, 32'h2468_ACE0, 12'h07E, 4'd6}
  };

  logic clk = 0, rst_n = 0;
  logic err_valid = 0; logic [1:0] err_kind = 0; logic [2:0] err_src = 0;
  logic [3:0] err_txn = 0; logic [31:0] err_addr = 0; logic [11:0] err_set = 0;
  logic [3:0] err_way = 0; logic acc_valid = 0; logic [31:0] acc_addr = 0;
  logic reg_wen = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, inj_mask; logic inj_ecc, inj_parity;
  int checks = 0, errors = 0; bit done = 0;

  always #(PER/2) clk = ~clk;

  cache_err_log u_dut (.clk, .rst_n, .err_valid, .err_kind, .err_src, .err_txn,
    .err_addr, .err_set, .err_way, .acc_valid, .acc_addr, .reg_wen, .reg_addr,
    .reg_wdata, .reg_rdata, .inj_ecc, .inj_parity, .inj_mask);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic set_err(logic [56:0] v);
    {err_kind, err_src, err_txn, err_addr, err_set, err_way} = v;
  endtask

  task automatic pulse(logic [56:0] v);
    @(negedge clk); set_err(v); err_valid = 1;
    @(negedge clk); err_valid = 0;
  endtask

  initial begin
    #(PER*190000);
    if (!done) begin
      errors++; $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int ce_m, ue_m;
    logic [56:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and unmapped words
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d); chk("R1 reset/unmapped word", d, 32'h0);
    end
    ce_m = 0; ue_m = 0;
    // table walk: R2 R5 R8
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      wr(3'd1, 32'h1);
      pulse(v);
      if (v[56:55] != 2'd3) begin
        if (v[56:55] == 2'd0) ce_m++; else ue_m++;
        rd(3'd1, d);
        chk("R5 attribute word", d, {13'd0, v[54:52], v[51:48], 2'd0, v[56:55], 7'd0, 1'b1});
        rd(3'd2, d); chk("R8 line address", d, {v[47:21], 5'd0});
        rd(3'd3, d); chk("R8 location word", d, {12'd0, v[15:4], 3'd0, v[3:0], 1'b0});
      end else begin
        rd(3'd1, d); chk("R2 class 3 not captured", {31'd0, d[0]}, 32'h0);
      end
      rd(3'd0, d); chk("R2 tallies", d, {1'b0, 15'(ue_m), 16'(ce_m)});
    end
    // R6: hold first record
    wr(3'd1, 32'h1);
    pulse(VEC[0]); pulse(VEC[2]);
    rd(3'd2, d); chk("R6 first error kept", d, {VEC[0][47:21], 5'd0});
    // R7: write zero has no effect
    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R7 write0 keeps held", {31'd0, d[0]}, 32'h1);
    // R7: drop and error in same cycle -> new capture
    @(negedge clk); reg_wen = 1; reg_addr = 3'd1; reg_wdata = 32'h1;
    set_err(VEC[5]); err_valid = 1;
    @(negedge clk); reg_wen = 0; err_valid = 0;
    rd(3'd3, d); chk("R7 same-cycle capture", d, {12'd0, VEC[5][15:4], 3'd0, VEC[5][3:0], 1'b0});
    // R4: clear
    wr(3'd0, 32'h8000_0000);
    rd(3'd0, d); chk("R4 clear tallies", d, 32'h0);
    // R3: correctable saturation
    @(negedge clk); set_err(VEC[0]); err_valid = 1;
    repeat (65540) @(negedge clk);
    err_valid = 0;
    rd(3'd0, d); chk("R3 ce saturates", d, 32'h0000_FFFF);
    @(negedge clk); set_err(VEC[2]); err_valid = 1;
    repeat (32771) @(negedge clk);
    err_valid = 0;
    rd(3'd0, d); chk("R3 ue saturates", d, 32'h7FFF_FFFF);
    // R4: clear with simultaneous uncorrectable error
    @(negedge clk); reg_wen = 1; reg_addr = 3'd0; reg_wdata = 32'h8000_0000;
    set_err(VEC[1]); err_valid = 1;
    @(negedge clk); reg_wen = 0; err_valid = 0;
    rd(3'd0, d); chk("R4 clear plus error", d, 32'h0001_0000);
    // R9/R10: injection
    wr(3'd5, 32'hDEAD_BEEF);
    @(negedge clk); chk("R9 mask output", inj_mask, 32'hDEAD_BEEF);
    wr(3'd4, 32'h1234_5671);
    rd(3'd4, d); chk("R9 control readback", d, 32'h1234_5671);
    @(negedge clk); acc_valid = 1; acc_addr = 32'h1234_5680; #1;
    chk("R10 no fire outside block", {30'd0, inj_ecc, inj_parity}, 32'h0);
    @(negedge clk); acc_addr = 32'h1234_567C; #1;
    chk("R10 ecc fires on match", {30'd0, inj_ecc, inj_parity}, 32'h2);
    @(negedge clk); #1;
    chk("R10 one shot", {30'd0, inj_ecc, inj_parity}, 32'h0);
    acc_valid = 0;
    rd(3'd4, d); chk("R10 enable self-cleared", {30'd0, d[1:0]}, 32'h0);
    wr(3'd4, 32'h0000_00A2);
    @(negedge clk); acc_valid = 1; acc_addr = 32'h0000_00A8; #1;
    chk("R9 parity fires", {30'd0, inj_ecc, inj_parity}, 32'h1);
    @(negedge clk); acc_valid = 0;
    wr(3'd4, 32'h0000_00A3);
    @(negedge clk); acc_valid = 1; #1;
    chk("R9 code 3 inert", {30'd0, inj_ecc, inj_parity}, 32'h0);
    @(negedge clk); acc_valid = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule